// File: doc/BRIEF.md
# Power Stage Fault Supervisor

This block sequences and protects a two-stage power converter: a boost power-factor front end followed by a resonant half-bridge. Analog comparators outside the block reduce the supply, the bulk-voltage feedback and the primary current to single-bit flags. The supervisor reads those flags, together with a strobe that marks each half-bridge switching-cycle boundary. It produces an enable for the boost stage, an enable for the half-bridge stage, a soft-start request, and a sticky fault status word that can be cleared by writing ones.

Start-up runs in a fixed order. First the supply must clear its upper threshold. The boost stage is then allowed to switch once the bulk feedback clears its permit level. The half-bridge starts on a cycle boundary once the bulk feedback clears a second, higher threshold, and every start opens with a soft-start window. A fast overcurrent stops the half-bridge at once. A slow overcurrent stops it only after it persists. A sagging bulk voltage also stops it. After any of these faults, the next start is again a full soft start. A bulk overvoltage blocks the boost stage and keeps it blocked for at least one complete switching cycle.

Top module: `psfs_supervisor`

## Requirements
- R1: While rst_n is low, pfc_en_o, llc_en_o and ss_req_o are 0 and fault_o is 0.
- R2: The supply run state is set by vcc_hi_i and cleared by vcc_lo_i, with clear taking priority. When neither flag is set, the previous state is kept. Without the run state, pfc_en_o is 0.
- R3: pfc_en_o is 1 only while the run state is set and the boost permit state is set. The boost permit state is set by bulk_pfc_hi_i and cleared by bulk_pfc_lo_i, and holds when neither is set.
- R4: A set bulk_ovp_i drives pfc_en_o to 0 three clocks later. After the flag clears, pfc_en_o stays 0 until OVP_HOLD_TICKS further llc_tick_i strobes have passed, and fault_o bit 0 is set.
- R5: The half-bridge starts only on a clock where llc_tick_i is 1. It also needs the run state set, the bulk run state set and no fast overcurrent. The bulk run state is set by bulk_run_hi_i, cleared by bulk_run_lo_i, and holds when neither is set. A start always enters soft start, so llc_en_o and ss_req_o both rise.
- R6: Soft start ends on the SS_TICKS-th llc_tick_i after the start strobe. ss_req_o then falls and llc_en_o stays 1.
- R7: A set ocp_fast_i turns llc_en_o off three clocks later, with no tick required, and sets fault_o bit 1. No start happens while the flag stays set.
- R8: ocp_slow_i turns the half-bridge off only when it is set on SLOW_TICKS consecutive llc_tick_i strobes, and then sets fault_o bit 2. Any strobe without the flag restarts the count.
- R9: Clearing the bulk run state while the half-bridge is on turns it off and sets fault_o bit 3. The half-bridge does not restart until bulk_run_hi_i sets the state again.
- R10: After any half-bridge fault, the next start begins a complete soft start of SS_TICKS strobes.
- R11: Fault bits are sticky. A clock with clr_valid_i high clears exactly the bits set in clr_mask_i, and leaves the other bits unchanged.
- R12: When the run state clears (undervoltage), both enables and ss_req_o go to 0 and fault_o clears to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| vcc_hi_i | input | 1 | Supply above upper undervoltage threshold (async) |
| vcc_lo_i | input | 1 | Supply below lower undervoltage threshold (async) |
| bulk_pfc_hi_i | input | 1 | Bulk feedback above boost permit level (async) |
| bulk_pfc_lo_i | input | 1 | Bulk feedback below boost inhibit level (async) |
| bulk_run_hi_i | input | 1 | Bulk feedback above half-bridge start level (async) |
| bulk_run_lo_i | input | 1 | Bulk feedback below half-bridge stop level (async) |
| bulk_ovp_i | input | 1 | Bulk overvoltage (async) |
| ocp_fast_i | input | 1 | Primary current above fast limit (async) |
| ocp_slow_i | input | 1 | Primary current above slow limit (async) |
| llc_tick_i | input | 1 | One-clock strobe at each half-bridge cycle boundary (synchronous) |
| clr_valid_i | input | 1 | Write strobe for fault clear |
| clr_mask_i | input | 4 | Write-one-to-clear mask for fault_o |
| pfc_en_o | output | 1 | Boost stage enable |
| llc_en_o | output | 1 | Half-bridge stage enable |
| ss_req_o | output | 1 | Soft-start request, frequency forced to maximum |
| fault_o | output | 4 | Sticky faults: bit0 overvoltage, bit1 fast OC, bit2 slow OC, bit3 bulk sag |

## Verification
The bench builds the supervisor with SS_TICKS = 16, SLOW_TICKS = 8 and OVP_HOLD_TICKS = 2. The short soft-start window lets a full soft start complete, and then a complete fresh soft start after a fault, within a few hundred clocks. The slow-overcurrent length stays at its real value, so the exact seventh-versus-eighth strobe boundary and the interrupted-run reset are both exercised. With the hold length at two, the run checks that the boost stage stays blocked after the first strobe and is released only after the second.

// File: rtl/psfs_pkg.sv
package psfs_pkg;
    localparam int FLT_W     = 4;
    localparam int FLT_OVP   = 0;
    localparam int FLT_FAST  = 1;
    localparam int FLT_SLOW  = 2;
    localparam int FLT_BROWN = 3;

    localparam int NFLAG        = 9;
    localparam int FL_VCC_HI    = 0;
    localparam int FL_VCC_LO    = 1;
    localparam int FL_PFC_HI    = 2;
    localparam int FL_PFC_LO    = 3;
    localparam int FL_RUN_HI    = 4;
    localparam int FL_RUN_LO    = 5;
    localparam int FL_OVP       = 6;
    localparam int FL_FAST      = 7;
    localparam int FL_SLOW      = 8;

    typedef enum logic [1:0] {
        LLC_OFF  = 2'd0,
        LLC_SOFT = 2'd1,
        LLC_RUN  = 2'd2
    } llc_state_e;
endpackage

// File: rtl/psfs_sync.sv
module psfs_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[s] <= '0;
                end else if (s == 0) begin
                    stage_q[s] <= async_i;
                end else begin
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/psfs_hyst.sv
module psfs_hyst (
    input  logic set_i,
    input  logic clr_i,
    input  logic state_q_i,
    output logic state_d_o
);
    always_comb begin
        if (clr_i) begin
            state_d_o = 1'b0;
        end else if (set_i) begin
            state_d_o = 1'b1;
        end else begin
            state_d_o = state_q_i;
        end
    end
endmodule

// File: rtl/psfs_ocp_qual.sv
module psfs_ocp_qual #(
    parameter int CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active_i,
    input  logic tick_i,
    input  logic slow_i,
    output logic trip_o
);
    localparam int CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;

    logic [CNT_W-1:0] cnt_d, cnt_q;

    assign trip_o = active_i && tick_i && slow_i && (cnt_q == CNT_W'(CYCLES-1));

    always_comb begin
        cnt_d = cnt_q;
        if (!active_i) begin
            cnt_d = '0;
        end else if (tick_i) begin
            if (!slow_i || trip_o) begin
                cnt_d = '0;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/psfs_supervisor.sv
module psfs_supervisor
    import psfs_pkg::*;
#(
    parameter int SYNC_STAGES    = 2,
    parameter int SS_TICKS       = 4096,
    parameter int SLOW_TICKS     = 8,
    parameter int OVP_HOLD_TICKS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vcc_hi_i,
    input  logic             vcc_lo_i,
    input  logic             bulk_pfc_hi_i,
    input  logic             bulk_pfc_lo_i,
    input  logic             bulk_run_hi_i,
    input  logic             bulk_run_lo_i,
    input  logic             bulk_ovp_i,
    input  logic             ocp_fast_i,
    input  logic             ocp_slow_i,
    input  logic             llc_tick_i,
    input  logic             clr_valid_i,
    input  logic [FLT_W-1:0] clr_mask_i,
    output logic             pfc_en_o,
    output logic             llc_en_o,
    output logic             ss_req_o,
    output logic [FLT_W-1:0] fault_o
);
    localparam int SS_W   = (SS_TICKS > 1) ? $clog2(SS_TICKS) : 1;
    localparam int HOLD_W = $clog2(OVP_HOLD_TICKS + 1);

    typedef struct packed {
        logic              run;
        logic              pfc_ok;
        logic              llc_ok;
        logic              pfc_en;
        llc_state_e        st;
        logic [SS_W-1:0]   ss_cnt;
        logic [HOLD_W-1:0] hold;
        logic [FLT_W-1:0]  flt;
    } sup_t;

    sup_t st_d, st_q;

    logic [NFLAG-1:0] flag_s;
    logic run_d, pfc_ok_d, llc_ok_d;
    logic slow_trip;

    logic run_q, pfc_ok_q, llc_ok_q, ovp_s, fast_s;
    assign run_q    = st_q.run;
    assign pfc_ok_q = st_q.pfc_ok;
    assign llc_ok_q = st_q.llc_ok;
    assign ovp_s    = flag_s[FL_OVP];
    assign fast_s   = flag_s[FL_FAST];

    psfs_sync #(.WIDTH(NFLAG), .STAGES(SYNC_STAGES)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({ocp_slow_i, ocp_fast_i, bulk_ovp_i, bulk_run_lo_i, bulk_run_hi_i,
                   bulk_pfc_lo_i, bulk_pfc_hi_i, vcc_lo_i, vcc_hi_i}),
        .sync_o  (flag_s)
    );

    psfs_hyst i_hyst_run (
        .set_i (flag_s[FL_VCC_HI]), .clr_i (flag_s[FL_VCC_LO]),
        .state_q_i (st_q.run), .state_d_o (run_d)
    );
    psfs_hyst i_hyst_pfc (
        .set_i (flag_s[FL_PFC_HI]), .clr_i (flag_s[FL_PFC_LO]),
        .state_q_i (st_q.pfc_ok), .state_d_o (pfc_ok_d)
    );
    psfs_hyst i_hyst_llc (
        .set_i (flag_s[FL_RUN_HI]), .clr_i (flag_s[FL_RUN_LO]),
        .state_q_i (st_q.llc_ok), .state_d_o (llc_ok_d)
    );

    psfs_ocp_qual #(.CYCLES(SLOW_TICKS)) i_ocp_qual (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (st_q.st != LLC_OFF),
        .tick_i   (llc_tick_i),
        .slow_i   (flag_s[FL_SLOW]),
        .trip_o   (slow_trip)
    );

    always_comb begin
        logic llc_on;
        logic stop;
        logic [FLT_W-1:0] set_bits;

        st_d        = st_q;
        st_d.run    = run_d;
        st_d.pfc_ok = pfc_ok_d;
        st_d.llc_ok = llc_ok_d;
        llc_on      = (st_q.st != LLC_OFF);
        set_bits    = '0;

        // overvoltage hold: reload while flagged, count strobes down afterwards
        if (ovp_s) begin
            st_d.hold = HOLD_W'(OVP_HOLD_TICKS);
        end else if (llc_tick_i && st_q.hold != '0) begin
            st_d.hold = st_q.hold - 1'b1;
        end
        st_d.pfc_en = run_d && pfc_ok_d && !ovp_s && (st_d.hold == '0);

        // half-bridge sequencing
        stop = !run_d || !llc_ok_d || fast_s || slow_trip;
        unique case (st_q.st)
            LLC_OFF: begin
                st_d.ss_cnt = '0;
                if (llc_tick_i && run_d && llc_ok_d && !fast_s) begin
                    st_d.st = LLC_SOFT;
                end
            end
            LLC_SOFT: begin
                if (stop) begin
                    st_d.st     = LLC_OFF;
                    st_d.ss_cnt = '0;
                end else if (llc_tick_i) begin
                    if (st_q.ss_cnt == SS_W'(SS_TICKS-1)) begin
                        st_d.st     = LLC_RUN;
                        st_d.ss_cnt = '0;
                    end else begin
                        st_d.ss_cnt = st_q.ss_cnt + 1'b1;
                    end
                end
            end
            LLC_RUN: begin
                if (stop) begin
                    st_d.st = LLC_OFF;
                end
            end
            default: begin
                st_d.st     = LLC_OFF;
                st_d.ss_cnt = '0;
            end
        endcase

        // sticky fault word
        set_bits[FLT_OVP]   = ovp_s;
        set_bits[FLT_FAST]  = llc_on && fast_s;
        set_bits[FLT_SLOW]  = slow_trip;
        set_bits[FLT_BROWN] = llc_on && !llc_ok_d;
        if (!run_d) begin
            st_d.flt = '0;
        end else begin
            st_d.flt = (st_q.flt & ~(clr_valid_i ? clr_mask_i : '0)) | set_bits;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{run: 1'b0, pfc_ok: 1'b0, llc_ok: 1'b0, pfc_en: 1'b0,
                      st: LLC_OFF, ss_cnt: '0, hold: '0, flt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign pfc_en_o = st_q.pfc_en;
    assign llc_en_o = (st_q.st != LLC_OFF);
    assign ss_req_o = (st_q.st == LLC_SOFT);
    assign fault_o  = st_q.flt;
endmodule

// File: rtl/psfs_checker.sv
module psfs_checker
    import psfs_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             pfc_en,
    input logic             llc_en,
    input logic             ss_req,
    input logic [FLT_W-1:0] fault,
    input logic             clr_valid,
    input logic             run_q,
    input logic             pfc_ok_q,
    input logic             llc_ok_q,
    input logic             ovp_s,
    input logic             fast_s
);
    AST_OVP_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        ovp_s |=> !pfc_en); // R4

    AST_FAST_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        fast_s |=> !llc_en); // R7

    AST_PFC_PERMIT: assert property (@(posedge clk) disable iff (!rst_n)
        pfc_en |-> (pfc_ok_q && run_q)); // R3

    AST_LLC_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(llc_en) |-> (llc_ok_q && ss_req)); // R5

    AST_UV_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q |-> (!pfc_en && !llc_en && fault == '0)); // R12

    AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && !clr_valid) |=> (!run_q || ((fault & $past(fault)) == $past(fault)))); // R11
endmodule

bind psfs_supervisor psfs_checker i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pfc_en    (pfc_en_o),
    .llc_en    (llc_en_o),
    .ss_req    (ss_req_o),
    .fault     (fault_o),
    .clr_valid (clr_valid_i),
    .run_q     (run_q),
    .pfc_ok_q  (pfc_ok_q),
    .llc_ok_q  (llc_ok_q),
    .ovp_s     (ovp_s),
    .fast_s    (fast_s)
);

// File: tb/test_psfs_supervisor.sv
module test_psfs_supervisor;
    localparam int SS  = 16;
    localparam int SLW = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       vcc_hi = 0, vcc_lo = 0, pfc_hi = 0, pfc_lo = 0;
    logic       run_hi = 0, run_lo = 0, ovp = 0, fast = 0, slow = 0;
    logic       tick = 0, clr_v = 0;
    logic [3:0] clr_m = '0;
    logic       pfc_en, llc_en, ss_req;
    logic [3:0] fault;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    psfs_supervisor #(.SS_TICKS(SS), .SLOW_TICKS(SLW), .OVP_HOLD_TICKS(2)) i_psfs_supervisor (
        .clk (clk), .rst_n (rst_n),
        .vcc_hi_i (vcc_hi), .vcc_lo_i (vcc_lo),
        .bulk_pfc_hi_i (pfc_hi), .bulk_pfc_lo_i (pfc_lo),
        .bulk_run_hi_i (run_hi), .bulk_run_lo_i (run_lo),
        .bulk_ovp_i (ovp), .ocp_fast_i (fast), .ocp_slow_i (slow),
        .llc_tick_i (tick), .clr_valid_i (clr_v), .clr_mask_i (clr_m),
        .pfc_en_o (pfc_en), .llc_en_o (llc_en), .ss_req_o (ss_req), .fault_o (fault)
    );

    // {vcc_hi, vcc_lo, pfc_hi, pfc_lo, expected pfc_en}
    localparam logic [4:0] VEC [10] = '{
        5'b0000_0, 5'b1000_0, 5'b1010_1, 5'b0000_1, 5'b0001_0,
        5'b0000_0, 5'b0010_1, 5'b0100_0, 5'b0000_0, 5'b1000_1
    };

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic pulse_tick(int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            step(1);
            tick = 1'b0;
            step(3);
        end
    endtask

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    initial begin
        #(4 * 20000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        step(3);
        check("R1 pfc_en", pfc_en, 0);
        check("R1 llc_en", llc_en, 0);
        check("R1 ss_req", ss_req, 0);
        check("R1 fault", fault, 0);
        rst_n = 1'b1;
        step(2);

        // R2 / R3 start-up order and hysteresis
        foreach (VEC[i]) begin
            {vcc_hi, vcc_lo, pfc_hi, pfc_lo} = VEC[i][4:1];
            step(6);
            check($sformatf("R2 R3 row %0d pfc_en", i), pfc_en, VEC[i][0]);
        end
        vcc_hi = 0;

        // R5 start only with bulk run state and a tick
        pulse_tick(1);
        check("R5 no start below run level", llc_en, 0);
        run_hi = 1;
        step(6);
        check("R5 no start without tick", llc_en, 0);
        pulse_tick(1);
        check("R5 start llc_en", llc_en, 1);
        check("R5 start ss_req", ss_req, 1);
        run_hi = 0;

        // R6 soft-start length
        pulse_tick(SS - 1);
        check("R6 ss still on", ss_req, 1);
        pulse_tick(1);
        check("R6 ss ended", ss_req, 0);
        check("R6 llc on", llc_en, 1);

        // R8 slow overcurrent qualification
        slow = 1;
        step(4);
        pulse_tick(SLW - 1);
        check("R8 seven strobes keep llc", llc_en, 1);
        pulse_tick(1);
        check("R8 eighth strobe trips", llc_en, 0);
        check("R8 fault bit2", fault, 4);
        slow = 0;
        step(4);

        // R10 fresh soft start after fault
        pulse_tick(1);
        check("R10 restart llc_en", llc_en, 1);
        check("R10 restart ss_req", ss_req, 1);
        pulse_tick(SS - 1);
        check("R10 full ss still on", ss_req, 1);
        pulse_tick(1);
        check("R10 full ss ended", ss_req, 0);

        // R8 interrupted run restarts count
        slow = 1;
        step(4);
        pulse_tick(5);
        slow = 0;
        step(4);
        pulse_tick(1);
        slow = 1;
        step(4);
        pulse_tick(SLW - 1);
        check("R8 interrupted count no trip", llc_en, 1);
        slow = 0;
        step(4);
        pulse_tick(1);

        // R11 write-one-to-clear
        clr_v = 1; clr_m = 4'b0001;
        step(1);
        clr_v = 0;
        step(2);
        check("R11 unmasked bit kept", fault, 4);
        clr_v = 1; clr_m = 4'b0100;
        step(1);
        clr_v = 0;
        step(2);
        check("R11 masked bit cleared", fault, 0);

        // R7 fast overcurrent
        fast = 1;
        step(4);
        check("R7 fast off", llc_en, 0);
        check("R7 fault bit1", fault, 2);
        pulse_tick(1);
        check("R7 no start while fast", llc_en, 0);
        fast = 0;
        step(4);
        pulse_tick(1);
        check("R10 restart after fast ss", ss_req, 1);

        // R4 overvoltage gating and hold
        ovp = 1;
        step(4);
        check("R4 pfc off", pfc_en, 0);
        check("R4 fault bit0", fault, 3);
        ovp = 0;
        step(6);
        check("R4 held after clear", pfc_en, 0);
        pulse_tick(1);
        check("R4 held after one strobe", pfc_en, 0);
        pulse_tick(1);
        check("R4 released after two strobes", pfc_en, 1);

        // R9 bulk sag
        run_lo = 1;
        step(4);
        check("R9 llc off on sag", llc_en, 0);
        check("R9 fault bit3", fault, 11);
        run_lo = 0;
        step(4);
        pulse_tick(1);
        check("R9 no restart in band", llc_en, 0);
        run_hi = 1;
        step(4);
        pulse_tick(1);
        check("R9 restart above start level", llc_en, 1);

        // R12 undervoltage
        vcc_lo = 1;
        step(6);
        check("R12 pfc off", pfc_en, 0);
        check("R12 llc off", llc_en, 0);
        check("R12 ss off", ss_req, 0);
        check("R12 fault cleared", fault, 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule